// File: doc/BRIEF.md
# Audio Serial Bit-Clock and Frame-Sync Generator

This block produces the timing for an audio serial port acting as clock master. A reference clock is divided down by a programmable amount to form the bit clock. Periods of that bit clock are counted into frames. A frame-sync signal marks the start of each frame, and its width and active level follow the selected audio format and the polarity controls. A single-cycle frame-start strobe tells the serializer that a new frame has begun.

The divisor, the frame length and the sync width are all programmed as the value minus one. In the default bit-clock polarity, data is meant to change on the falling bit-clock edge and be sampled on the rising edge, so frames begin at a falling edge. The generator runs only while its enable is high. When the enable is low, every counter returns to its start point and the outputs rest at their idle levels.

Top module: `audio_bclk_fs_gen`

## Requirements
- R1: While `rst_n` is low, or `en` was low at the last clock edge, `bclk_o` equals `bclk_inv`, `fsync_o` is at its inactive level (see R7), and `fstart_o` is 0.
- R2: Counting the clock edges that sample `en` high as n = 1, 2, ..., the internal bit clock, before any inversion, is 0 at start and toggles after every D = `div_m1`+1 such edges. Its period is therefore 2·D reference cycles, so `div_m1` = 0 gives half the reference rate.
- R3: The frame counter advances at each falling edge of the internal bit clock and wraps after `fper_m1`+1 bit clocks. The first falling edge after enable starts frame bit 0.
- R4: `fstart_o` is high for exactly one reference cycle, in the cycle in which the internal bit clock has just fallen and the frame counter has just wrapped to bit 0. The first such cycle is at n = 2·D.
- R5: With `fmt` = 0 (I2S), the frame sync is active for bits 0 to `wid_m1` of each frame, that is `wid_m1`+1 bit clocks.
- R6: With `fmt` = 1 (DSP-A), 2 (DSP-B) or 3 (handled as DSP-B), the frame sync is active for bit 0 only, whatever the value of `wid_m1`.
- R7: With `fs_inv` = 0, the active level of `fsync_o` is low in I2S mode and high in the DSP modes. `fs_inv` = 1 swaps the active level in every mode.
- R8: `bclk_o` is the internal bit clock XOR `bclk_inv`. With `bclk_inv` = 0, every frame start coincides with a falling edge of `bclk_o`.
- R9: Between enable and the first frame start, `fsync_o` stays inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the generator at its start point |
| div_m1 | input | DIV_W | Bit-clock half-period in reference cycles, minus one |
| fper_m1 | input | CNT_W | Bit clocks per frame, minus one |
| wid_m1 | input | CNT_W | I2S sync width in bit clocks, minus one |
| fmt | input | 2 | Format: 0 I2S, 1 DSP-A, 2 DSP-B, 3 as DSP-B |
| bclk_inv | input | 1 | Invert the bit-clock output |
| fs_inv | input | 1 | Invert the frame-sync polarity |
| bclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame sync |
| fstart_o | output | 1 | One-cycle frame-start strobe |

## Verification
The bench sweeps three divisors (including zero), two frame lengths, two I2S widths, all four format codes and all four polarity pairs. It checks every reference cycle of more than two frames against a cycle-count model. The divisor sweep separates a correct half-period from an off-by-one in the divider. The width and format sweep shows that I2S follows `wid_m1` and that the DSP codes ignore it. The polarity sweep tells the format-dependent sync inversion apart from the plain bit-clock inversion. The cycles before the first falling edge check that the sync stays idle until a frame exists.

// File: rtl/abfg_pkg.sv
package abfg_pkg;
  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_DSPA = 2'd1,
    FMT_DSPB = 2'd2,
    FMT_RSVD = 2'd3
  } fmt_e;

  function automatic logic is_dsp(input logic [1:0] f);
    return f != FMT_I2S;
  endfunction
endpackage

// File: rtl/abfg_clk_div.sv
module abfg_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_m1,
  output logic             raw_bclk,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             bclk_q, bclk_d;
  logic             tick;

  always_comb begin
    tick   = (cnt_q == div_m1);
    cnt_d  = cnt_q;
    bclk_d = bclk_q;
    if (!en) begin
      cnt_d  = '0;
      bclk_d = 1'b0;
    end else if (tick) begin
      cnt_d  = '0;
      bclk_d = ~bclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
    end
  end

  assign raw_bclk  = bclk_q;
  assign fall_tick = en & tick & bclk_q;
endmodule

// File: rtl/abfg_frame_cnt.sv
module abfg_frame_cnt #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fall_tick,
  input  logic [CNT_W-1:0] fper_m1,
  output logic [CNT_W-1:0] bit_idx,
  output logic             running,
  output logic             fstart
);
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             run_q, run_d;
  logic             stb_q, stb_d;
  logic             wrap;

  always_comb begin
    wrap  = (idx_q == fper_m1);
    idx_d = idx_q;
    run_d = run_q;
    stb_d = 1'b0;
    if (!en) begin
      idx_d = fper_m1;
      run_d = 1'b0;
    end else if (fall_tick) begin
      idx_d = wrap ? '0 : idx_q + 1'b1;
      run_d = 1'b1;
      stb_d = wrap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      run_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      run_q <= run_d;
      stb_q <= stb_d;
    end
  end

  assign bit_idx = idx_q;
  assign running = run_q;
  assign fstart  = stb_q;
endmodule

// File: rtl/abfg_shaper.sv
module abfg_shaper
  import abfg_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             raw_bclk,
  input  logic             running,
  input  logic [CNT_W-1:0] bit_idx,
  input  logic [CNT_W-1:0] wid_m1,
  input  logic [1:0]       fmt,
  input  logic             bclk_inv,
  input  logic             fs_inv,
  output logic             bclk_o,
  output logic             fsync_o
);
  logic [CNT_W-1:0] wid_eff;
  logic             active;
  logic             low_active;

  always_comb begin
    wid_eff    = is_dsp(fmt) ? '0 : wid_m1;
    active     = running && (bit_idx <= wid_eff);
    low_active = ~(fs_inv ^ is_dsp(fmt));
    fsync_o    = active ^ low_active;
    bclk_o     = raw_bclk ^ bclk_inv;
  end
endmodule

// File: rtl/audio_bclk_fs_gen.sv
module audio_bclk_fs_gen #(
  parameter int DIV_W = 8,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_m1,
  input  logic [CNT_W-1:0] fper_m1,
  input  logic [CNT_W-1:0] wid_m1,
  input  logic [1:0]       fmt,
  input  logic             bclk_inv,
  input  logic             fs_inv,
  output logic             bclk_o,
  output logic             fsync_o,
  output logic             fstart_o
);
  logic             raw_bclk;
  logic             fall_tick;
  logic [CNT_W-1:0] bit_idx;
  logic             running;

  abfg_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en(en), .div_m1(div_m1),
    .raw_bclk(raw_bclk), .fall_tick(fall_tick)
  );

  abfg_frame_cnt #(.CNT_W(CNT_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .en(en), .fall_tick(fall_tick),
    .fper_m1(fper_m1), .bit_idx(bit_idx), .running(running),
    .fstart(fstart_o)
  );

  abfg_shaper #(.CNT_W(CNT_W)) u_shp (
    .raw_bclk(raw_bclk), .running(running), .bit_idx(bit_idx),
    .wid_m1(wid_m1), .fmt(fmt), .bclk_inv(bclk_inv), .fs_inv(fs_inv),
    .bclk_o(bclk_o), .fsync_o(fsync_o)
  );
endmodule

// File: rtl/audio_bclk_fs_gen_chk.sv
module audio_bclk_fs_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [1:0] fmt,
  input logic       bclk_inv,
  input logic       fs_inv,
  input logic       bclk_o,
  input logic       fsync_o,
  input logic       fstart_o
);
  logic act_lvl;
  assign act_lvl = fs_inv ^ (fmt != 2'd0);

  // R1: idle bit clock after a disabled edge
  a_r1_idle_bclk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (bclk_o == bclk_inv));
  // R1: no strobe after a disabled edge
  a_r1_idle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !fstart_o);
  // R4: strobe lasts one cycle
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    fstart_o |=> !fstart_o);
  // R8: strobe sits on a bit-clock falling edge
  a_r8_fall_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (fstart_o && $past(en)) |-> (!(bclk_o ^ bclk_inv) && $past(bclk_o ^ bclk_inv)));
  // R5: sync active at frame start
  a_r5_sync_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    fstart_o |-> (fsync_o == act_lvl));
endmodule

bind audio_bclk_fs_gen audio_bclk_fs_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .fmt(fmt), .bclk_inv(bclk_inv),
  .fs_inv(fs_inv), .bclk_o(bclk_o), .fsync_o(fsync_o), .fstart_o(fstart_o)
);

// File: tb/audio_bclk_fs_gen_tb.sv
module audio_bclk_fs_gen_tb;
  localparam int DIV_W = 8;
  localparam int CNT_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic [DIV_W-1:0] div_m1 = '0;
  logic [CNT_W-1:0] fper_m1 = '0;
  logic [CNT_W-1:0] wid_m1 = '0;
  logic [1:0]       fmt = '0;
  logic             bclk_inv = 1'b0;
  logic             fs_inv = 1'b0;
  logic             bclk_o, fsync_o, fstart_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  audio_bclk_fs_gen #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .div_m1(div_m1), .fper_m1(fper_m1),
    .wid_m1(wid_m1), .fmt(fmt), .bclk_inv(bclk_inv), .fs_inv(fs_inv),
    .bclk_o(bclk_o), .fsync_o(fsync_o), .fstart_o(fstart_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t div=%0d per=%0d wid=%0d fmt=%0d bi=%0d fi=%0d act=%0b exp=%0b",
               req, $time, div_m1, fper_m1, wid_m1, fmt, bclk_inv, fs_inv, act, exp);
    end
  endtask

  function automatic logic inactive_lvl(input logic [1:0] f, input logic fi);
    return ~(fi ^ (f != 2'd0));
  endfunction

  task automatic run_cfg(input int d1, input int p1, input int w1,
                         input int f, input int bi, input int fi);
    int D, P, N, fall, idx, weff;
    logic raw, run, act, stb;
    @(negedge clk);
    en = 1'b0; div_m1 = DIV_W'(d1); fper_m1 = CNT_W'(p1); wid_m1 = CNT_W'(w1);
    fmt = 2'(f); bclk_inv = bi[0]; fs_inv = fi[0];
    @(negedge clk);
    // R1: disabled state
    chk("R1 bclk idle", bclk_o, bi[0]);
    chk("R1 fsync idle", fsync_o, inactive_lvl(fmt, fs_inv));
    chk("R1 fstart idle", fstart_o, 1'b0);
    en = 1'b1;
    D = d1 + 1; P = p1 + 1;
    weff = (f == 0) ? w1 : 0;
    N = 2 * D * P * 2 + 2 * D + 3;
    for (int n = 1; n <= N; n++) begin
      @(negedge clk);
      raw  = ((n / D) % 2) != 0;
      fall = n / (2 * D);
      run  = fall >= 1;
      idx  = run ? (fall - 1) % P : 0;
      stb  = run && (n % (2 * D) == 0) && (idx == 0);
      act  = run && (idx <= weff);
      // R2 / R8: bit clock and its inversion
      chk("R2 R8 bclk", bclk_o, raw ^ bi[0]);
      // R3 / R4: frame strobe placement
      chk("R3 R4 fstart", fstart_o, stb);
      // R5 / R6 / R7 / R9: sync shape, width and level
      if (!run)
        chk("R9 fsync before frame", fsync_o, inactive_lvl(fmt, fs_inv));
      else if (f == 0)
        chk("R5 R7 fsync i2s", fsync_o, act ^ inactive_lvl(fmt, fs_inv));
      else
        chk("R6 R7 fsync dsp", fsync_o, act ^ inactive_lvl(fmt, fs_inv));
    end
    en = 1'b0;
  endtask

  initial begin
    #3;
    // R1: state under reset
    chk("R1 reset bclk", bclk_o, 1'b0);
    chk("R1 reset fstart", fstart_o, 1'b0);
    chk("R1 reset fsync", fsync_o, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    for (int d = 0; d < 3; d++)
      for (int p = 0; p < 2; p++)
        for (int w = 0; w < 2; w++)
          for (int f = 0; f < 4; f++)
            for (int pol = 0; pol < 4; pol++)
              run_cfg(d, (p == 0) ? 3 : 7, (w == 0) ? 1 : 3, f, pol & 1, pol >> 1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        vectors++;
        errors++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule